// File: doc/BRIEF.md
# Shifter-Fronted Arithmetic-Logic Unit

This block is a 32-bit arithmetic-logic unit whose second operand first passes through a barrel shifter. Each operand has its own enable: a disabled operand counts as zero. The first operand can also be complemented after gating. The shifted second operand then goes into one of seven operations, chosen by a sparse 4-bit code: three bitwise logic operations, add, subtract, move and move-inverted. The add can take an extra carry-in.

The datapath is purely combinational. A single output register stage holds the result and the four condition flags: negative, zero, carry and overflow. A result therefore appears one clock after its inputs are presented. Any code outside the seven defined ones gives a zero result with every flag clear. The unit is meant to sit in the execute stage of a small processor or as a data-manipulation engine in a larger datapath.

Top module: `shift_alu`

## Requirements
- R1: When `a_en` is 0, operand A counts as zero. When `b_en` is 0, operand B counts as zero before shifting. When `a_inv` is 1, the gated A is bitwise complemented.
- R2: A shift kind of 00 shifts the gated B left by `sh_amt` positions and fills with zeros. A kind of 01 shifts it right the same way. For both, the carry of a logic or move operation is the last bit shifted out.
- R3: A shift kind of 10 shifts the gated B right and copies bit 31 into the vacated positions.
- R4: A shift kind of 11 rotates the gated B right, so the low bits wrap into the top. An amount of 0 passes B through unchanged. For a rotate with a non-zero amount, the shift carry equals result bit 31.
- R5: Code 0000 gives A AND Bs, code 0001 gives A XOR Bs, and code 1100 gives A OR Bs. Here Bs is the shifted B.
- R6: Code 0100 gives A + Bs + `carry_en`.
- R7: Code 0010 gives A + ~Bs + 1. The `carry_en` input has no effect on it.
- R8: Code 1101 outputs Bs, and code 1111 outputs ~Bs.
- R9: For every defined code, `flag_n` equals result bit 31, and `flag_z` is 1 exactly when the result is zero.
- R10: For add and subtract, `flag_c` is the carry out of the 32-bit adder and `flag_v` is the signed-overflow condition.
- R11: For logic and move codes, `flag_v` is 0 and `flag_c` is the shifter carry. The shifter carry is 0 when `sh_amt` is 0.
- R12: Any code other than the seven defined ones gives a zero result and clears all four flags, including `flag_z`.
- R13: The result and flags are registered and appear one clock after the inputs. A synchronous active-high `rst` clears them all to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B (shifted) |
| a_en | input | 1 | Operand A enable |
| b_en | input | 1 | Operand B enable |
| a_inv | input | 1 | Complement gated A |
| carry_en | input | 1 | Extra carry-in for add |
| sh_amt | input | 5 | Shift distance 0..31 |
| sh_kind | input | 2 | Shift kind: 00 left, 01 right, 10 arithmetic right, 11 rotate |
| op_code | input | 4 | Operation code |
| res_q | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest cases to reach from the ports are the edges of the carry and overflow flags. Examples are the shift carry at distances 1 and 31, and the difference between a rotate by zero and a rotate by a non-zero amount. Another is the undefined operation codes, whose zero result must still leave the zero flag clear. The stimulus is built as raw vector words, and undefined codes and boundary shift distances are placed in them on purpose. The fields are cast into the enumerated operation and shift types before they are driven. A reference model in the bench then predicts the result and all four flags for each vector.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_XOR = 4'b0001,
        OP_SUB = 4'b0010,
        OP_ADD = 4'b0100,
        OP_ORR = 4'b1100,
        OP_MOV = 4'b1101,
        OP_MVN = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic op_is_defined(logic [3:0] code);
        return (code == OP_AND) || (code == OP_XOR) || (code == OP_SUB) ||
               (code == OP_ADD) || (code == OP_ORR) || (code == OP_MOV) ||
               (code == OP_MVN);
    endfunction

    function automatic logic op_is_logical(logic [3:0] code);
        return (code == OP_AND) || (code == OP_XOR) || (code == OP_ORR) ||
               (code == OP_MOV) || (code == OP_MVN);
    endfunction

endpackage

// File: rtl/operand_gate.sv
module operand_gate #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_raw,
    input  logic [W-1:0] b_raw,
    input  logic         a_en,
    input  logic         b_en,
    input  logic         a_inv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out
);
    logic [W-1:0] a_gated;

    always_comb begin
        a_gated = a_en ? a_raw : '0;
        a_out   = a_inv ? ~a_gated : a_gated;
        b_out   = b_en ? b_raw : '0;
    end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
    import shift_alu_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic [1:0]     kind,
    output logic [W-1:0]   dout,
    output logic           cout
);
    shift_kind_e kind_e;
    assign kind_e = shift_kind_e'(kind);

    for (genvar gi = 0; gi < SHW; gi++) begin : g_stage
        localparam int D = 1 << gi;
        logic [W-1:0] src;
        logic [W-1:0] moved;
        logic [W-1:0] out;

        if (gi == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = g_stage[gi-1].out;
        end

        always_comb begin
            unique case (kind_e)
                SH_LSL:  moved = src << D;
                SH_LSR:  moved = src >> D;
                SH_ASR:  moved = W'($signed(src) >>> D);
                SH_ROR:  moved = {src[D-1:0], src[W-1:D]};
                default: moved = src;
            endcase
        end

        assign out = amt[gi] ? moved : src;
    end

    assign dout = g_stage[SHW-1].out;

    logic [SHW-1:0] left_idx;
    logic [SHW-1:0] right_idx;

    always_comb begin
        left_idx  = ~amt + 1'b1;
        right_idx = amt - 1'b1;
        cout      = 1'b0;
        if (amt != '0) begin
            if (kind_e == SH_LSL) cout = din[left_idx];
            else                  cout = din[right_idx];
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import shift_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] bs,
    input  logic [3:0]   op,
    input  logic         carry_en,
    input  logic         sh_c,
    output logic [W-1:0] result,
    output flags_t       flags
);
    logic [W:0]   sum;
    logic [W-1:0] addend;
    logic         arith;
    logic         known;

    always_comb begin
        sum    = '0;
        addend = bs;
        arith  = 1'b0;
        known  = 1'b1;
        result = '0;
        case (op)
            OP_AND: result = a & bs;
            OP_XOR: result = a ^ bs;
            OP_ORR: result = a | bs;
            OP_MOV: result = bs;
            OP_MVN: result = ~bs;
            OP_ADD: begin
                arith  = 1'b1;
                addend = bs;
                sum    = {1'b0, a} + {1'b0, addend} + (W+1)'(carry_en);
                result = sum[W-1:0];
            end
            OP_SUB: begin
                arith  = 1'b1;
                addend = ~bs;
                sum    = {1'b0, a} + {1'b0, addend} + (W+1)'(1);
                result = sum[W-1:0];
            end
            default: begin
                known  = 1'b0;
                result = '0;
            end
        endcase

        flags = '0;
        if (known) begin
            flags.n = result[W-1];
            flags.z = (result == '0);
            if (arith) begin
                flags.c = sum[W];
                flags.v = (a[W-1] == addend[W-1]) && (result[W-1] != a[W-1]);
            end else begin
                flags.c = sh_c;
                flags.v = 1'b0;
            end
        end
    end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import shift_alu_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic           a_en,
    input  logic           b_en,
    input  logic           a_inv,
    input  logic           carry_en,
    input  logic [SHW-1:0] sh_amt,
    input  logic [1:0]     sh_kind,
    input  logic [3:0]     op_code,
    output logic [W-1:0]   res_q,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_c,
    output logic           flag_v
);
    logic [W-1:0] a_g, b_g, b_sh, res_d;
    logic         sh_c;
    flags_t       flags_d, flags_q;

    operand_gate #(.W(W)) u_gate (
        .a_raw(a_in), .b_raw(b_in), .a_en(a_en), .b_en(b_en),
        .a_inv(a_inv), .a_out(a_g), .b_out(b_g)
    );

    barrel_shifter #(.W(W)) u_shift (
        .din(b_g), .amt(sh_amt), .kind(sh_kind), .dout(b_sh), .cout(sh_c)
    );

    alu_core #(.W(W)) u_core (
        .a(a_g), .bs(b_sh), .op(op_code), .carry_en(carry_en),
        .sh_c(sh_c), .result(res_d), .flags(flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= res_d;
            flags_q <= flags_d;
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // R12
    undefined_op_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !op_is_defined(op_code) |=> (res_q == '0 && flags_q == '0));

    // R11
    logic_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        op_is_logical(op_code) |=> !flag_v);

    // R11
    zero_shift_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_is_logical(op_code) && sh_amt == '0) |=> !flag_c);

    // R4
    rotate_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_MOV && sh_kind == SH_ROR && sh_amt != '0) |=> (flag_c == res_q[W-1]));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_z |-> (res_q == '0));
endmodule

// File: tb/shift_alu_tb.sv
module shift_alu_tb;
    import shift_alu_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  flg;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_in = '0, b_in = '0;
    logic        a_en = 1'b0, b_en = 1'b0, a_inv = 1'b0, carry_en = 1'b0;
    logic [4:0]  sh_amt = '0;
    shift_kind_e sh_kind = SH_LSL;
    alu_op_e     op_code = OP_AND;
    logic [31:0] res_q;
    logic        flag_n, flag_z, flag_c, flag_v;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];

    shift_alu u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .a_en(a_en),
        .b_en(b_en), .a_inv(a_inv), .carry_en(carry_en), .sh_amt(sh_amt),
        .sh_kind(sh_kind), .op_code(op_code), .res_q(res_q),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [78:0] mk(logic [31:0] a, logic [31:0] b,
            logic ea, logic eb, logic ia, logic ce, logic [4:0] amt,
            logic [1:0] sh, logic [3:0] op);
        return {op, sh, amt, ce, ia, eb, ea, b, a};
    endfunction

    function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic ea,
            logic eb, logic ia, logic ce, logic [4:0] amt, shift_kind_e sh,
            alu_op_e op);
        exp_t        e;
        logic [31:0] ag, bg, bs, r;
        logic [63:0] t;
        logic [32:0] s;
        logic        sc, n, z, c, v;
        ag = ea ? a : 32'h0;
        if (ia) ag = ~ag;
        bg = eb ? b : 32'h0;
        sc = 1'b0;
        case (sh)
            SH_LSL: begin t = {32'h0, bg} << amt; bs = t[31:0]; sc = t[32]; end
            SH_LSR: begin t = {bg, 32'h0} >> amt; bs = t[63:32]; sc = t[31]; end
            SH_ASR: begin t = 64'($signed({bg, 32'h0}) >>> amt); bs = t[63:32]; sc = t[31]; end
            default: begin t = {bg, bg} >> amt; bs = t[31:0]; sc = (amt != 0) ? bs[31] : 1'b0; end
        endcase
        if (amt == 0) sc = 1'b0;
        r = 32'h0; c = sc; v = 1'b0;
        case (op)
            OP_AND: r = ag & bs;
            OP_XOR: r = ag ^ bs;
            OP_ORR: r = ag | bs;
            OP_MOV: r = bs;
            OP_MVN: r = ~bs;
            OP_ADD: begin
                s = {1'b0, ag} + {1'b0, bs} + {32'h0, ce};
                r = s[31:0]; c = s[32];
                v = ($signed(ag) >= 0) == ($signed(bs) >= 0) && (r[31] != ag[31]);
            end
            OP_SUB: begin
                s = {1'b0, ag} + {1'b0, ~bs} + 33'd1;
                r = s[31:0]; c = s[32];
                v = (ag[31] != bs[31]) && (r[31] != ag[31]);
            end
            default: begin
                e.res = 32'h0; e.flg = 4'h0; e.tag = ""; return e;
            end
        endcase
        n = r[31];
        z = (r == 32'h0);
        e.res = r;
        e.flg = {n, z, c, v};
        e.tag = "";
        return e;
    endfunction

    task automatic drive(logic [78:0] vec, string tag);
        exp_t e;
        @(negedge clk);
        a_in     = vec[31:0];
        b_in     = vec[63:32];
        a_en     = vec[64];
        b_en     = vec[65];
        a_inv    = vec[66];
        carry_en = vec[67];
        sh_amt   = vec[72:68];
        sh_kind  = shift_kind_e'(vec[74:73]);
        op_code  = alu_op_e'(vec[78:75]);
        e = model(a_in, b_in, a_en, b_en, a_inv, carry_en, sh_amt, sh_kind, op_code);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (res_q !== e.res || {flag_n, flag_z, flag_c, flag_v} !== e.flg) begin
                n_errors++;
                $display("FAIL %s res=%h exp=%h flags=%b exp=%b", e.tag, res_q,
                         e.res, {flag_n, flag_z, flag_c, flag_v}, e.flg);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL R13 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    logic [31:0] rs;
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (res_q !== 32'h0 || {flag_n, flag_z, flag_c, flag_v} !== 4'h0) begin
            n_errors++;
            $display("FAIL R13 reset res=%h exp=0 flags=%b exp=0000", res_q,
                     {flag_n, flag_z, flag_c, flag_v});
        end
        rst = 1'b0;

        // R1 operand gating and inversion
        drive(mk(32'h5, 32'h3, 0, 1, 0, 0, 0, SH_LSL, OP_ADD), "R1");
        drive(mk(32'h1234, 32'h1, 0, 1, 1, 0, 0, SH_LSL, OP_ADD), "R1");
        drive(mk(32'h0, 32'hFF, 1, 0, 0, 0, 3, SH_LSL, OP_MOV), "R1");
        drive(mk(32'h0F0F_00FF, 32'hFFFF_FFFF, 1, 1, 1, 0, 0, SH_LSR, OP_AND), "R1");
        // R2 logical shifts
        drive(mk(32'h0, 32'h8000_0001, 1, 1, 0, 0, 4, SH_LSL, OP_MOV), "R2");
        drive(mk(32'h0, 32'h8000_0001, 1, 1, 0, 0, 1, SH_LSL, OP_MOV), "R2");
        drive(mk(32'h0, 32'h0000_0003, 1, 1, 0, 0, 1, SH_LSR, OP_MOV), "R2");
        drive(mk(32'h0, 32'hFFFF_FFFF, 1, 1, 0, 0, 31, SH_LSR, OP_MOV), "R2");
        // R3 arithmetic right
        drive(mk(32'h0, 32'h8000_0000, 1, 1, 0, 0, 4, SH_ASR, OP_MOV), "R3");
        drive(mk(32'h0, 32'h8000_0000, 1, 1, 0, 0, 31, SH_ASR, OP_MOV), "R3");
        drive(mk(32'h0, 32'h4000_0000, 1, 1, 0, 0, 30, SH_ASR, OP_MOV), "R3");
        // R4 rotate
        drive(mk(32'h0, 32'h1234_5678, 1, 1, 0, 0, 8, SH_ROR, OP_MOV), "R4");
        drive(mk(32'h0, 32'hDEAD_BEEF, 1, 1, 0, 0, 0, SH_ROR, OP_MOV), "R4");
        drive(mk(32'h0, 32'h0000_0001, 1, 1, 0, 0, 1, SH_ROR, OP_MOV), "R4");
        // R5 logic operations
        drive(mk(32'hF0F0_F0F0, 32'hFF00_FF00, 1, 1, 0, 0, 0, SH_LSL, OP_AND), "R5");
        drive(mk(32'hF0F0_F0F0, 32'hFF00_FF00, 1, 1, 0, 0, 0, SH_LSL, OP_XOR), "R5");
        drive(mk(32'hF0F0_F0F0, 32'h0000_000F, 1, 1, 0, 0, 4, SH_LSL, OP_ORR), "R5");
        // R6 add with carry-in
        drive(mk(32'h1, 32'h2, 1, 1, 0, 1, 0, SH_LSL, OP_ADD), "R6");
        drive(mk(32'h1, 32'h2, 1, 1, 0, 0, 0, SH_LSL, OP_ADD), "R6");
        drive(mk(32'hFFFF_FFFF, 32'h1, 1, 1, 0, 0, 0, SH_LSL, OP_ADD), "R6");
        // R7 subtract ignores carry-in
        drive(mk(32'h5, 32'h3, 1, 1, 0, 0, 0, SH_LSL, OP_SUB), "R7");
        drive(mk(32'h5, 32'h3, 1, 1, 0, 1, 0, SH_LSL, OP_SUB), "R7");
        drive(mk(32'h3, 32'h5, 1, 1, 0, 1, 0, SH_LSL, OP_SUB), "R7");
        // R8 move and move-inverted
        drive(mk(32'h0, 32'h0, 1, 1, 0, 0, 0, SH_LSL, OP_MVN), "R8");
        drive(mk(32'h0, 32'h0000_00AB, 1, 1, 0, 0, 8, SH_LSL, OP_MVN), "R8");
        // R9 zero and negative
        drive(mk(32'hAAAA_AAAA, 32'h5555_5555, 1, 1, 0, 0, 0, SH_LSL, OP_AND), "R9");
        drive(mk(32'h8000_0000, 32'h0, 1, 1, 0, 0, 0, SH_LSL, OP_ORR), "R9");
        // R10 overflow and carry of the adder
        drive(mk(32'h7FFF_FFFF, 32'h1, 1, 1, 0, 0, 0, SH_LSL, OP_ADD), "R10");
        drive(mk(32'h8000_0000, 32'h1, 1, 1, 0, 0, 0, SH_LSL, OP_SUB), "R10");
        drive(mk(32'h8000_0000, 32'h8000_0000, 1, 1, 0, 0, 0, SH_LSL, OP_ADD), "R10");
        // R11 shift carry on logic operations
        drive(mk(32'h0, 32'h0000_0010, 1, 1, 0, 0, 5, SH_LSR, OP_XOR), "R11");
        drive(mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0, 0, SH_LSL, OP_AND), "R11");
        // R12 undefined codes
        drive(mk(32'h1234, 32'h5678, 1, 1, 0, 1, 3, SH_LSL, 4'b0011), "R12");
        drive(mk(32'hFFFF_FFFF, 32'h1, 1, 1, 0, 0, 0, SH_LSL, 4'b1110), "R12");
        drive(mk(32'h0, 32'h0, 1, 1, 0, 0, 0, SH_LSL, 4'b1000), "R12");

        // R9 R13 mixed pseudo-random vectors
        rs = 32'hC0FF_EE11;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb, rc;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5); ra = rs;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5); rb = rs;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5); rc = rs;
            drive(mk(ra, rb, rc[0] | rc[20], rc[1] | rc[21], rc[2] & rc[22],
                     rc[3], rc[8:4], rc[10:9], rc[14:11]), "R9");
        end

        repeat (3) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule